// File: doc/BRIEF.md
# Utility-Based Way Partitioner

This block decides how the ways of a shared set-associative cache are divided between two clients: a CPU application and a GPU application. Each client supplies one hit counter per recency stack position, from the most recently used position to the least recently used one. When a go pulse arrives, the block takes a snapshot of both counter vectors, the access-rate ratio and the squeeze input. It divides every GPU counter by the ratio. It then grants ways greedily, and each grant goes to the client whose best run of further ways gives the highest hits per way.

The block returns two way counts, registered, together with a one-cycle done pulse. The replacement logic that enforces the split uses these counts. If the squeeze input is set, the search is skipped. The GPU gets a single way and the CPU gets the rest. The hit counters are filled outside this block.

Top module: `way_partitioner`

## Requirements
- R1: While reset is held and after it is released, busy_o and done_o are 0 and cpu_ways_o and gpu_ways_o are 0, until the first go is accepted.
- R2: Each completed run reports cpu_ways_o + gpu_ways_o equal to WAYS, and each count is at least 1.
- R3: Counter vectors are packed with stack position i (0 = most recently used) in bits [i*HIT_W +: HIT_W]. Each client starts with one way. The remaining ways are handed out in rounds. In each round, a client that already holds a ways considers granting n more ways, for 1 <= n <= remaining. The value of such a grant is the sum of its counters at positions a to a+n-1, divided by n. Each client keeps its best n. The client with the better value receives its n ways. Example: CPU {16,3,8,20,5,8,3,2}, GPU {32,6,16,40,10,16,6,4}, ratio 1 gives 1 CPU way and 7 GPU ways.
- R4: Before allocation, every GPU counter is replaced by floor(counter / ratio). A ratio input of 0 behaves as 1. With the R3 counters, ratio 2 gives 4 CPU ways and 4 GPU ways.
- R5: A go accepted with squeeze_i = 1 yields cpu_ways_o = WAYS-1 and gpu_ways_o = 1, whatever the counters are, with done_o high in the cycle right after go.
- R6: Values per way are compared by cross-multiplication. An exact tie between the clients goes to the CPU. Inside one client, a tie keeps the smaller n. With all counters equal (zero included), the result is WAYS-1 CPU ways and 1 GPU way.
- R7: A go that arrives while busy_o is 1 is ignored: the running job's result is unchanged and no extra done pulse follows.
- R8: For a run without squeeze, busy_o is 1 in the cycle after go and stays high until done. done_o is a single-cycle pulse with busy_o low, and the way counts are valid in that cycle.
- R9: A go arriving in the same cycle that done_o is high is accepted and starts a new run.
- R10: Counters, ratio and squeeze are sampled only when go is accepted; changing them during a run has no effect on its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go_i | input | 1 | Start pulse, taken while idle |
| squeeze_i | input | 1 | Force the GPU down to one way |
| ratio_i | input | RATIO_W | GPU counter divisor (0 acts as 1) |
| cpu_hits_i | input | WAYS*HIT_W | CPU hit counters, MRU at bit 0 |
| gpu_hits_i | input | WAYS*HIT_W | GPU hit counters, MRU at bit 0 |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cpu_ways_o | output | $clog2(WAYS+1) | Ways granted to the CPU |
| gpu_ways_o | output | $clog2(WAYS+1) | Ways granted to the GPU |

## Verification
Completion and start can fall in the same cycle. The bench provokes this by raising go in the very cycle it sees done_o. It then checks that the old counts are valid during that cycle, that busy_o rises one cycle later, and that the second run finishes with the counts the arithmetic model gives for the new counters. A go during a run is also provoked, with squeeze set and changed counters held on the ports. The bench judges that the run still returns the model's result for the original snapshot and that no stray done pulse follows.

// File: rtl/wpart_pkg.sv
package wpart_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCALE_GO,
    ST_SCALE_WAIT,
    ST_SCAN_GO,
    ST_SCAN_WAIT
  } wp_state_e;
endpackage

// File: rtl/wpart_div.sv
// Restoring serial divider: one quotient bit per cycle.
module wpart_div #(
  parameter int NUM_W = 16,
  parameter int DEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [NUM_W-1:0] quo_o
);
  localparam int CNT_W  = $clog2(NUM_W + 1);
  localparam int PROD_W = NUM_W + DEN_W + 1;

  logic [NUM_W-1:0] num_q, quo_q;
  logic [DEN_W-1:0] den_q, rem_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic [DEN_W:0]   shifted, trial;

  assign shifted = {rem_q, quo_q[NUM_W-1]};
  assign trial   = shifted - {1'b0, den_q};
  assign quo_o   = quo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      num_q  <= '0;
      den_q  <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        num_q <= num_i;
        den_q <= den_i;
        quo_q <= num_i;
        rem_q <= '0;
        cnt_q <= CNT_W'(NUM_W);
        run_q <= 1'b1;
      end else if (run_q) begin
        if (shifted >= {1'b0, den_q}) begin
          rem_q <= trial[DEN_W-1:0];
          quo_q <= {quo_q[NUM_W-2:0], 1'b1};
        end else begin
          rem_q <= shifted[DEN_W-1:0];
          quo_q <= {quo_q[NUM_W-2:0], 1'b0};
        end
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          run_q  <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  // R4: the finished quotient is the floor of num / den
  p_div_exact_r4: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ((PROD_W'(quo_q) * PROD_W'(den_q) + PROD_W'(rem_q) == PROD_W'(num_q))
                && (rem_q < den_q)));
endmodule

// File: rtl/wpart_scan.sv
// Walks one client's counters from a base position, tracking the best
// hits-per-way run length without any divider.
module wpart_scan #(
  parameter int HIT_W = 16,
  parameter int IDX_W = 3,
  parameter int NW    = 4,
  parameter int SUM_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [IDX_W-1:0] base_i,
  input  logic [NW-1:0]    limit_i,
  output logic [IDX_W-1:0] rd_idx_o,
  input  logic [HIT_W-1:0] rd_hit_i,
  output logic             done_o,
  output logic [SUM_W-1:0] best_sum_o,
  output logic [NW-1:0]    best_n_o
);
  localparam int PW = SUM_W + NW;

  logic [IDX_W-1:0] idx_q;
  logic [NW-1:0]    step_q, lim_q, n_nx;
  logic [SUM_W-1:0] acc_q, acc_nx;
  logic             run_q, take;
  logic [PW-1:0]    lhs, rhs;

  assign rd_idx_o = idx_q;
  assign acc_nx   = acc_q + SUM_W'(rd_hit_i);
  assign n_nx     = step_q + 1'b1;
  assign lhs      = PW'(acc_nx) * PW'(best_n_o);
  assign rhs      = PW'(best_sum_o) * PW'(n_nx);
  // strict compare: an equal rate keeps the shorter run (R6)
  assign take     = (best_n_o == '0) || (lhs > rhs);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q      <= '0;
      step_q     <= '0;
      lim_q      <= '0;
      acc_q      <= '0;
      run_q      <= 1'b0;
      done_o     <= 1'b0;
      best_sum_o <= '0;
      best_n_o   <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        idx_q      <= base_i;
        step_q     <= '0;
        lim_q      <= limit_i;
        acc_q      <= '0;
        run_q      <= 1'b1;
        best_sum_o <= '0;
        best_n_o   <= '0;
      end else if (run_q) begin
        acc_q  <= acc_nx;
        step_q <= n_nx;
        idx_q  <= idx_q + 1'b1;
        if (take) begin
          best_sum_o <= acc_nx;
          best_n_o   <= n_nx;
        end
        if (n_nx == lim_q) begin
          run_q  <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  // R3: a finished scan proposes between one way and the remaining count
  p_best_range_r3: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (best_n_o >= NW'(1)) && (best_n_o <= lim_q));
endmodule

// File: rtl/way_partitioner.sv
module way_partitioner
  import wpart_pkg::*;
#(
  parameter int WAYS    = 8,
  parameter int HIT_W   = 16,
  parameter int RATIO_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       go_i,
  input  logic                       squeeze_i,
  input  logic [RATIO_W-1:0]         ratio_i,
  input  logic [WAYS*HIT_W-1:0]      cpu_hits_i,
  input  logic [WAYS*HIT_W-1:0]      gpu_hits_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic [$clog2(WAYS+1)-1:0]  cpu_ways_o,
  output logic [$clog2(WAYS+1)-1:0]  gpu_ways_o
);
  localparam int IDX_W = $clog2(WAYS);
  localparam int NW    = $clog2(WAYS + 1);
  localparam int SUM_W = HIT_W + NW;
  localparam int PW    = SUM_W + NW;
  localparam int APPS  = 2;  // index 0 = CPU, 1 = GPU

  wp_state_e state_q;

  logic [HIT_W-1:0]   cpu_mem [WAYS];
  logic [HIT_W-1:0]   gpu_mem [WAYS];
  logic [RATIO_W-1:0] ratio_q;
  logic [IDX_W-1:0]   div_idx_q;
  logic [APPS-1:0][NW-1:0] alloc_q, alloc_nx;
  logic [NW-1:0]      rem_q, rem_nx, grant_n;

  logic               div_start, div_done;
  logic [HIT_W-1:0]   div_quo;

  logic                          scan_start;
  logic [APPS-1:0]               scan_done;
  logic [APPS-1:0][IDX_W-1:0]    rd_idx;
  logic [APPS-1:0][HIT_W-1:0]    rd_hit;
  logic [APPS-1:0][SUM_W-1:0]    best_sum;
  logic [APPS-1:0][NW-1:0]       best_n;
  logic                          cpu_pref;

  assign busy_o     = (state_q != ST_IDLE);
  assign div_start  = (state_q == ST_SCALE_GO);
  assign scan_start = (state_q == ST_SCAN_GO);

  // Counter snapshot, GPU entries rewritten in place by the divider
  always_ff @(posedge clk) begin
    if (state_q == ST_IDLE && go_i) begin
      for (int i = 0; i < WAYS; i++) begin
        cpu_mem[i] <= cpu_hits_i[i*HIT_W +: HIT_W];
        gpu_mem[i] <= gpu_hits_i[i*HIT_W +: HIT_W];
      end
    end else if (state_q == ST_SCALE_WAIT && div_done) begin
      gpu_mem[div_idx_q] <= div_quo;
    end
  end

  wpart_div #(.NUM_W(HIT_W), .DEN_W(RATIO_W)) u_div (
    .clk     (clk),
    .rst     (rst),
    .start_i (div_start),
    .num_i   (gpu_mem[div_idx_q]),
    .den_i   (ratio_q),
    .done_o  (div_done),
    .quo_o   (div_quo)
  );

  for (genvar a = 0; a < APPS; a++) begin : g_app
    if (a == 0) begin : g_cpu
      assign rd_hit[a] = cpu_mem[rd_idx[a]];
    end else begin : g_gpu
      assign rd_hit[a] = gpu_mem[rd_idx[a]];
    end
    wpart_scan #(.HIT_W(HIT_W), .IDX_W(IDX_W), .NW(NW), .SUM_W(SUM_W)) u_scan (
      .clk        (clk),
      .rst        (rst),
      .start_i    (scan_start),
      .base_i     (alloc_q[a][IDX_W-1:0]),
      .limit_i    (rem_q),
      .rd_idx_o   (rd_idx[a]),
      .rd_hit_i   (rd_hit[a]),
      .done_o     (scan_done[a]),
      .best_sum_o (best_sum[a]),
      .best_n_o   (best_n[a])
    );
  end

  // Cross-multiplied rate comparison; equality favours the CPU (R6)
  always_comb begin
    cpu_pref = (PW'(best_sum[0]) * PW'(best_n[1])) >= (PW'(best_sum[1]) * PW'(best_n[0]));
    grant_n  = cpu_pref ? best_n[0] : best_n[1];
    alloc_nx = alloc_q;
    if (cpu_pref) alloc_nx[0] = alloc_q[0] + grant_n;
    else          alloc_nx[1] = alloc_q[1] + grant_n;
    rem_nx   = rem_q - grant_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      ratio_q    <= '0;
      div_idx_q  <= '0;
      alloc_q    <= '0;
      rem_q      <= '0;
      done_o     <= 1'b0;
      cpu_ways_o <= '0;
      gpu_ways_o <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (go_i) begin
            ratio_q <= (ratio_i == '0) ? RATIO_W'(1) : ratio_i;
            if (squeeze_i) begin
              cpu_ways_o <= NW'(WAYS - 1);
              gpu_ways_o <= NW'(1);
              done_o     <= 1'b1;
            end else begin
              alloc_q   <= {NW'(1), NW'(1)};
              rem_q     <= NW'(WAYS - 2);
              div_idx_q <= '0;
              state_q   <= ST_SCALE_GO;
            end
          end
        end
        ST_SCALE_GO: state_q <= ST_SCALE_WAIT;
        ST_SCALE_WAIT: begin
          if (div_done) begin
            if (div_idx_q == IDX_W'(WAYS - 1)) begin
              if (rem_q == '0) begin
                cpu_ways_o <= alloc_q[0];
                gpu_ways_o <= alloc_q[1];
                done_o     <= 1'b1;
                state_q    <= ST_IDLE;
              end else begin
                state_q <= ST_SCAN_GO;
              end
            end else begin
              div_idx_q <= div_idx_q + 1'b1;
              state_q   <= ST_SCALE_GO;
            end
          end
        end
        ST_SCAN_GO: state_q <= ST_SCAN_WAIT;
        ST_SCAN_WAIT: begin
          if (scan_done[0]) begin
            alloc_q <= alloc_nx;
            rem_q   <= rem_nx;
            if (rem_nx == '0) begin
              cpu_ways_o <= alloc_nx[0];
              gpu_ways_o <= alloc_nx[1];
              done_o     <= 1'b1;
              state_q    <= ST_IDLE;
            end else begin
              state_q <= ST_SCAN_GO;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2: a reported split covers every way and leaves each client one
  p_ways_total_r2: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ((NW+1)'(cpu_ways_o) + (NW+1)'(gpu_ways_o) == (NW+1)'(WAYS))
               && (cpu_ways_o != '0) && (gpu_ways_o != '0));

  // R2: during a run, granted and remaining ways always add up to WAYS
  p_alloc_balance_r2: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> ((NW+2)'(alloc_q[0]) + (NW+2)'(alloc_q[1]) + (NW+2)'(rem_q) == (NW+2)'(WAYS)));

  // R5: squeeze answers in the next cycle with a single GPU way
  p_squeeze_r5: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && go_i && squeeze_i) |=> done_o && (gpu_ways_o == NW'(1))
                                       && (cpu_ways_o == NW'(WAYS - 1)));

  // R8: completion is reported only once the engine is idle again
  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  // R8: a plain go makes the block busy in the following cycle
  p_busy_start_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && go_i && !squeeze_i) |=> busy_o);
endmodule

// File: tb/way_partitioner_test.sv
`timescale 1ns/1ps
module way_partitioner_test;
  localparam int WAYS = 8;
  localparam int HW   = 16;
  localparam int RW   = 8;
  localparam int NW   = $clog2(WAYS + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic go = 1'b0;
  logic squeeze = 1'b0;
  logic [RW-1:0] ratio = '0;
  logic [WAYS*HW-1:0] cpu_hits = '0, gpu_hits = '0;
  logic busy, done;
  logic [NW-1:0] cpu_ways, gpu_ways;

  int checks = 0;
  int errors = 0;
  int c_arr [WAYS];
  int g_arr [WAYS];
  int unsigned seed = 32'h1234_5678;

  always #4 clk = ~clk;

  way_partitioner #(.WAYS(WAYS), .HIT_W(HW), .RATIO_W(RW)) uut (
    .clk(clk), .rst(rst), .go_i(go), .squeeze_i(squeeze), .ratio_i(ratio),
    .cpu_hits_i(cpu_hits), .gpu_hits_i(gpu_hits), .busy_o(busy), .done_o(done),
    .cpu_ways_o(cpu_ways), .gpu_ways_o(gpu_ways)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  // Greedy allocation computed from the requirement text
  task automatic model(input int r_in, input bit sq, output int oc, output int og);
    int r, rem;
    int al [2];
    int hits [2][WAYS];
    longint bs [2];
    int bn [2];
    r = (r_in == 0) ? 1 : r_in;
    for (int i = 0; i < WAYS; i++) begin
      hits[0][i] = c_arr[i];
      hits[1][i] = g_arr[i] / r;
    end
    if (sq) begin
      oc = WAYS - 1; og = 1;
      return;
    end
    al[0] = 1; al[1] = 1; rem = WAYS - 2;
    while (rem > 0) begin
      for (int a = 0; a < 2; a++) begin
        longint acc;
        acc = 0; bs[a] = 0; bn[a] = 0;
        for (int n = 1; n <= rem; n++) begin
          acc += hits[a][al[a] + n - 1];
          if (bn[a] == 0 || acc * bn[a] > bs[a] * n) begin
            bs[a] = acc; bn[a] = n;
          end
        end
      end
      if (bs[0] * bn[1] >= bs[1] * bn[0]) begin
        al[0] += bn[0]; rem -= bn[0];
      end else begin
        al[1] += bn[1]; rem -= bn[1];
      end
    end
    oc = al[0]; og = al[1];
  endtask

  task automatic pack_inputs();
    for (int i = 0; i < WAYS; i++) begin
      cpu_hits[i*HW +: HW] = c_arr[i][HW-1:0];
      gpu_hits[i*HW +: HW] = g_arr[i][HW-1:0];
    end
  endtask

  task automatic drive(input bit sq, input int r);
    pack_inputs();
    squeeze = sq;
    ratio = r[RW-1:0];
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done == 1'b1, "R8 done reached", int'(done), 1);
  endtask

  task automatic run_and_check(input bit sq, input int r, input string tag);
    int ec, eg, cyc;
    model(r, sq, ec, eg);
    drive(sq, r);
    if (!sq) chk(busy == 1'b1, "R8 busy after go", int'(busy), 1);
    wait_done(cyc);
    chk(int'(cpu_ways) == ec, {tag, " cpu ways"}, int'(cpu_ways), ec);
    chk(int'(gpu_ways) == eg, {tag, " gpu ways"}, int'(gpu_ways), eg);
    chk(int'(cpu_ways) + int'(gpu_ways) == WAYS && cpu_ways != 0 && gpu_ways != 0,
        "R2 total", int'(cpu_ways) + int'(gpu_ways), WAYS);
    chk(busy == 1'b0, "R8 idle at done", int'(busy), 0);
    @(negedge clk);
    chk(done == 1'b0, "R8 done single pulse", int'(done), 0);
  endtask

  task automatic load_example();
    int cv [WAYS] = '{16, 3, 8, 20, 5, 8, 3, 2};
    for (int i = 0; i < WAYS; i++) begin
      c_arr[i] = cv[i];
      g_arr[i] = 2 * cv[i];
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int ec, eg, cyc;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0, "R1 outputs in reset", int'(busy) + int'(done), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0, "R1 flags after reset", int'(busy) + int'(done), 0);
    chk(cpu_ways == 0 && gpu_ways == 0, "R1 ways after reset",
        int'(cpu_ways) + int'(gpu_ways), 0);

    // R3 worked example, ratio 1 -> 1 CPU / 7 GPU
    load_example();
    run_and_check(1'b0, 1, "R3 example");
    chk(cpu_ways == 1 && gpu_ways == 7, "R3 example literal", int'(gpu_ways), 7);
    // R4 ratio 2 -> 4 / 4, ratio 0 acts as 1
    run_and_check(1'b0, 2, "R4 ratio two");
    chk(cpu_ways == 4 && gpu_ways == 4, "R4 example literal", int'(cpu_ways), 4);
    run_and_check(1'b0, 0, "R4 ratio zero");
    chk(gpu_ways == 7, "R4 zero as one", int'(gpu_ways), 7);

    // R5 squeeze: answer in the cycle after go
    drive(1'b1, 1);
    chk(done == 1'b1, "R5 done next cycle", int'(done), 1);
    chk(cpu_ways == WAYS - 1 && gpu_ways == 1, "R5 squeeze split", int'(gpu_ways), 1);
    @(negedge clk);

    // R6 ties: zero counters and equal counters both favour the CPU
    for (int i = 0; i < WAYS; i++) begin c_arr[i] = 0; g_arr[i] = 0; end
    run_and_check(1'b0, 1, "R6 all zero");
    chk(cpu_ways == WAYS - 1, "R6 zero tie to cpu", int'(cpu_ways), WAYS - 1);
    for (int i = 0; i < WAYS; i++) begin c_arr[i] = 5; g_arr[i] = 5; end
    run_and_check(1'b0, 1, "R6 all equal");
    chk(cpu_ways == WAYS - 1, "R6 equal tie to cpu", int'(cpu_ways), WAYS - 1);

    // R3/R4 sweep over ratios and counter patterns
    for (int t = 0; t < 80; t++) begin
      for (int i = 0; i < WAYS; i++) begin
        c_arr[i] = (t % 2 == 0) ? int'(rnd() % 64) : int'(rnd() % 65536);
        g_arr[i] = (t % 3 == 0) ? int'(rnd() % 64) : int'(rnd() % 65536);
      end
      run_and_check(1'b0, t % 5, "R3 sweep");
    end

    // R7 + R10: go with squeeze and new counters while busy is ignored
    load_example();
    model(1, 1'b0, ec, eg);
    drive(1'b0, 1);
    @(negedge clk);
    for (int i = 0; i < WAYS; i++) begin c_arr[i] = 0; g_arr[i] = 999; end
    pack_inputs();
    ratio = 8'd7;
    squeeze = 1'b1;
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    wait_done(cyc);
    chk(int'(cpu_ways) == ec && int'(gpu_ways) == eg, "R7 busy go ignored",
        int'(gpu_ways), eg);
    chk(int'(cpu_ways) == ec, "R10 snapshot kept", int'(cpu_ways), ec);
    begin
      int extra;
      extra = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (done) extra++;
      end
      chk(extra == 0, "R7 no extra done", extra, 0);
    end

    // R9: go raised in the cycle done is high
    load_example();
    drive(1'b0, 2);
    wait_done(cyc);
    chk(cpu_ways == 4 && gpu_ways == 4, "R9 first result", int'(cpu_ways), 4);
    for (int i = 0; i < WAYS; i++) begin c_arr[i] = 0; g_arr[i] = 0; end
    drive(1'b0, 1);
    chk(busy == 1'b1, "R9 restart accepted", int'(busy), 1);
    wait_done(cyc);
    chk(cpu_ways == WAYS - 1 && gpu_ways == 1, "R9 second result",
        int'(cpu_ways), WAYS - 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule